// File: doc/BRIEF.md
# Multi-source software interrupt tracker

This block holds the pending state of software-generated interrupts (SGIs) inside an interrupt distributor that serves a configurable number of CPUs, at most eight. For each target CPU and each of the 16 SGI numbers it keeps an 8-bit mask with one bit per source CPU. A single SGI can therefore be pending on one target from several sources at the same time, and the block reports every source that raised it.

A CPU raises an SGI through the generate port. It gives its own CPU number, the SGI number and a mask of target CPUs. Each target CPU has its own acknowledge port, clear port and read port. On the acknowledge port the target sees the SGI it would take next, together with the CPU that raised it. Asserting the acknowledge request takes that SGI and removes only that one source. On the clear port the target removes chosen source bits of one SGI. The read port returns the target's source masks four SGIs to a word.

Top module: `sgi_src_tracker`

## Requirements
- R1: After a synchronous active-low reset, every source mask of every target CPU reads zero.
- R2: A generate request (gen_valid high) sets bit gen_src of the source mask of SGI gen_sgi on every target CPU c whose bit gen_targets[c] is 1. The state changes at the next rising clock edge.
- R3: A generate request with an all-zero target mask, or with gen_src not below NUM_CPU, changes no source mask.
- R4: rd_data for CPU c is combinational. Byte k of the word (bits 8k+7..8k) is the source mask of SGI 4*rd_idx[c]+k on CPU c, and bit s of that byte is source CPU s.
- R5: ack_value for CPU c is combinational. Bits 9:0 hold the lowest-numbered SGI that has a nonzero source mask on c. Bits 12:10 hold the lowest-numbered source bit set in that mask.
- R6: Asserting ack_req[c] while an SGI is pending on c clears only the reported source bit, at the next edge. The other source bits of that SGI stay set, and the SGI stays pending while any of them remain.
- R7: With no SGI pending on CPU c, ack_value reads ID 1023 with source field 0. Asserting ack_req[c] then changes no state.
- R8: clr_valid[c] clears, on CPU c only, the source bits given by clr_mask in the mask of SGI clr_id.
- R9: When a generate request sets a bit in the same cycle that an acknowledge or a clear removes it, the bit is set after the edge.
- R10: In a cycle with no generate, no acknowledge of a pending SGI and no clear write, no source mask changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_valid | input | 1 | Generate request strobe |
| gen_src | input | 3 | Number of the CPU raising the SGI |
| gen_sgi | input | 4 | SGI number to raise |
| gen_targets | input | NUM_CPU | One bit per target CPU |
| ack_req | input | NUM_CPU | Per-CPU acknowledge strobe |
| ack_value | output | 13*NUM_CPU | Per-CPU {source[2:0], id[9:0]}, CPU c at bits 13c+12..13c |
| clr_valid | input | NUM_CPU | Per-CPU clear-by-source write strobe |
| clr_id | input | 4*NUM_CPU | Per-CPU SGI number for the clear write |
| clr_mask | input | 8*NUM_CPU | Per-CPU source bits to clear |
| rd_idx | input | 2*NUM_CPU | Per-CPU read word index (four SGIs per word) |
| rd_data | output | 32*NUM_CPU | Per-CPU read word of source masks |

## Verification
The bench aims at these cases:
- Two sources on the same SGI and target. A design that kept one flag per SGI would report the wrong source, or would drop the second source after the first acknowledge.
- A generate and an acknowledge of the same bit in the same cycle. A design that let the clear win would lose the new request.
- Clear writes that name a source mask on one CPU. A design that cleared every CPU's copy would show up in the other CPUs' read words.
- Empty target masks, out-of-range sources, and acknowledges with nothing pending. These must leave every read word unchanged and return ID 1023.

// File: rtl/sgi_pkg.sv
// Package: shared constants for the SGI source tracker.
// Assumes at most eight CPUs, so a source number fits in three bits.
package sgi_pkg;
    localparam int SGI_COUNT = 16;
    localparam int SGI_ID_W  = $clog2(SGI_COUNT);
    localparam int MAX_CPU   = 8;
    localparam int SRC_W     = $clog2(MAX_CPU);
    localparam int INTID_W   = 10;
    localparam int ACK_W     = INTID_W + SRC_W;
    localparam int RD_W      = 32;
    localparam int PER_WORD  = RD_W / MAX_CPU;
    localparam int RD_WORDS  = SGI_COUNT / PER_WORD;
    localparam int RD_IDX_W  = $clog2(RD_WORDS);
    localparam logic [INTID_W-1:0] SPURIOUS_ID = 10'd1023;
endpackage

// File: rtl/sgi_pick.sv
// Module: sgi_pick
// Picks the lowest-numbered SGI that has any source bit set. For that SGI
// it also picks the lowest-numbered source bit. Purely combinational.
// Assumes the masks come straight from one target CPU's storage.
module sgi_pick
    import sgi_pkg::*;
#(
    parameter int NUM_SGI = SGI_COUNT
) (
    input  logic [NUM_SGI-1:0][MAX_CPU-1:0] masks,
    output logic                            hit,
    output logic [SGI_ID_W-1:0]             id,
    output logic [SRC_W-1:0]                src
);
    // Scan downward so that the lowest pending index is written last.
    always_comb begin
        hit = 1'b0;
        id  = '0;
        src = '0;
        for (int i = NUM_SGI - 1; i >= 0; i--) begin
            if (|masks[i]) begin
                hit = 1'b1;
                id  = SGI_ID_W'(i);
            end
        end
        for (int s = MAX_CPU - 1; s >= 0; s--) begin
            if (masks[id][s]) src = SRC_W'(s);
        end
    end

    // R5
    pick_src_set_chk: assert final (!hit || masks[id][src]);
endmodule

// File: rtl/sgi_target_bank.sv
// Module: sgi_target_bank
// Source-mask storage for one target CPU. It applies generate sets,
// acknowledge clears and clear-by-source writes, and presents the
// acknowledge value and the read word.
// Assumes gen_sel is already qualified by valid, target bit and source range.
module sgi_target_bank
    import sgi_pkg::*;
#(
    parameter int NUM_SGI = SGI_COUNT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gen_sel,
    input  logic [SGI_ID_W-1:0] gen_sgi,
    input  logic [SRC_W-1:0]    gen_src,
    input  logic                ack_req,
    input  logic                clr_valid,
    input  logic [SGI_ID_W-1:0] clr_id,
    input  logic [MAX_CPU-1:0]  clr_mask,
    input  logic [RD_IDX_W-1:0] rd_idx,
    output logic [ACK_W-1:0]    ack_value,
    output logic [RD_W-1:0]     rd_data
);
    logic [NUM_SGI-1:0][MAX_CPU-1:0] mask_q;
    logic [NUM_SGI-1:0][MAX_CPU-1:0] set_v;
    logic [NUM_SGI-1:0][MAX_CPU-1:0] clr_v;
    logic                            pick_hit;
    logic [SGI_ID_W-1:0]             pick_id;
    logic [SRC_W-1:0]                pick_src;
    logic                            ack_fire;

    sgi_pick #(.NUM_SGI(NUM_SGI)) u_pick (
        .masks (mask_q),
        .hit   (pick_hit),
        .id    (pick_id),
        .src   (pick_src)
    );

    assign ack_fire = ack_req && pick_hit;

    // Build the per-bit set and clear vectors for this cycle.
    always_comb begin
        set_v = '0;
        clr_v = '0;
        if (gen_sel) set_v[gen_sgi][gen_src] = 1'b1;
        if (ack_fire) clr_v[pick_id][pick_src] = 1'b1;
        if (clr_valid) clr_v[clr_id] = clr_v[clr_id] | clr_mask;
    end

    // Storage update: clears first, then sets, so a generate wins.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= (mask_q & ~clr_v) | set_v;
    end

    // Acknowledge value: {source, id} or the spurious ID.
    always_comb begin
        if (pick_hit) ack_value = {pick_src, INTID_W'(pick_id)};
        else          ack_value = {{SRC_W{1'b0}}, SPURIOUS_ID};
    end

    // Read word: four consecutive SGI masks, lowest SGI in the low byte.
    always_comb begin
        for (int k = 0; k < PER_WORD; k++) begin
            rd_data[k*MAX_CPU +: MAX_CPU] = mask_q[int'(rd_idx) * PER_WORD + k];
        end
    end

    // R9
    gen_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_sel |=> mask_q[$past(gen_sgi)][$past(gen_src)]);

    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire && !gen_sel |=> !mask_q[$past(pick_id)][$past(pick_src)]);

    // R6
    ack_one_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire && !gen_sel && !clr_valid |=>
        ($countones(mask_q[$past(pick_id)]) + 1 == $countones($past(mask_q[pick_id]))));

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_sel && !ack_fire && !clr_valid |=> $stable(mask_q));
endmodule

// File: rtl/sgi_src_tracker.sv
// Module: sgi_src_tracker
// Top level. It qualifies generate requests and fans them out to one
// storage bank per target CPU. Per-CPU ports are flat vectors, with CPU c
// in slice c.
// Assumes NUM_CPU is between 1 and 8.
module sgi_src_tracker
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_SGI = SGI_COUNT
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        gen_valid,
    input  logic [SRC_W-1:0]            gen_src,
    input  logic [SGI_ID_W-1:0]         gen_sgi,
    input  logic [NUM_CPU-1:0]          gen_targets,
    input  logic [NUM_CPU-1:0]          ack_req,
    output logic [NUM_CPU*ACK_W-1:0]    ack_value,
    input  logic [NUM_CPU-1:0]          clr_valid,
    input  logic [NUM_CPU*SGI_ID_W-1:0] clr_id,
    input  logic [NUM_CPU*MAX_CPU-1:0]  clr_mask,
    input  logic [NUM_CPU*RD_IDX_W-1:0] rd_idx,
    output logic [NUM_CPU*RD_W-1:0]     rd_data
);
    logic gen_ok;

    // A request counts only if it comes from an existing source CPU.
    assign gen_ok = gen_valid && (int'(gen_src) < NUM_CPU);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        sgi_target_bank #(.NUM_SGI(NUM_SGI)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .gen_sel   (gen_ok && gen_targets[c]),
            .gen_sgi   (gen_sgi),
            .gen_src   (gen_src),
            .ack_req   (ack_req[c]),
            .clr_valid (clr_valid[c]),
            .clr_id    (clr_id[c*SGI_ID_W +: SGI_ID_W]),
            .clr_mask  (clr_mask[c*MAX_CPU +: MAX_CPU]),
            .rd_idx    (rd_idx[c*RD_IDX_W +: RD_IDX_W]),
            .ack_value (ack_value[c*ACK_W +: ACK_W]),
            .rd_data   (rd_data[c*RD_W +: RD_W])
        );
    end
endmodule

// File: tb/sgi_src_tracker_tb.sv
// Bench: drives directed corner cases and then a seeded random mix. Every
// cycle it checks the acknowledge value and the read word of every CPU
// against a behavioural model.
module sgi_src_tracker_tb;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_valid = 1'b0;
    logic [2:0]  gen_src = '0;
    logic [3:0]  gen_sgi = '0;
    logic [NC-1:0] gen_targets = '0;
    logic [NC-1:0] ack_req = '0;
    logic [NC*13-1:0] ack_value;
    logic [NC-1:0] clr_valid = '0;
    logic [NC*4-1:0] clr_id = '0;
    logic [NC*8-1:0] clr_mask = '0;
    logic [NC*2-1:0] rd_idx = '0;
    logic [NC*32-1:0] rd_data;

    logic [7:0] m  [NC][16];
    logic [7:0] nm [NC][16];
    int total = 0;
    int fails = 0;
    bit done = 0;

    sgi_src_tracker #(.NUM_CPU(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .gen_valid(gen_valid), .gen_src(gen_src),
        .gen_sgi(gen_sgi), .gen_targets(gen_targets), .ack_req(ack_req),
        .ack_value(ack_value), .clr_valid(clr_valid), .clr_id(clr_id),
        .clr_mask(clr_mask), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    function automatic logic [12:0] exp_ack(int c);
        for (int i = 0; i < 16; i++)
            for (int s = 0; s < 8; s++)
                if (m[c][i][s]) return {3'(s), 10'(i)};
        return {3'd0, 10'd1023};
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Check outputs mid-cycle, then advance one edge and update the model.
    task automatic step(string tag);
        logic [12:0] a;
        logic [31:0] w;
        #1;
        for (int c = 0; c < NC; c++) begin
            a = exp_ack(c);
            chk({tag, " R5 ack"}, 32'(ack_value[c*13 +: 13]), 32'(a));
            for (int k = 0; k < 4; k++)
                w[k*8 +: 8] = m[c][int'(rd_idx[c*2 +: 2])*4 + k];
            chk({tag, " R4 read"}, rd_data[c*32 +: 32], w);
        end
        nm = m;
        for (int c = 0; c < NC; c++) begin
            a = exp_ack(c);
            if (ack_req[c] && a[9:0] != 10'd1023) nm[c][a[3:0]][a[12:10]] = 1'b0;
            if (clr_valid[c])
                nm[c][clr_id[c*4 +: 4]] = nm[c][clr_id[c*4 +: 4]] & ~clr_mask[c*8 +: 8];
        end
        if (gen_valid && gen_src < 3'(NC))
            for (int c = 0; c < NC; c++)
                if (gen_targets[c]) nm[c][gen_sgi][gen_src] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        m = nm;
    endtask

    task automatic idle();
        gen_valid = 0; ack_req = '0; clr_valid = '0;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) for (int i = 0; i < 16; i++) m[c][i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: every word zero after reset, R7: spurious ID on empty acknowledge
        for (int w = 0; w < 4; w++) begin
            rd_idx = {NC{2'(w)}};
            ack_req = '1;
            step("R1 R7");
        end
        idle();
        rd_idx = {NC{2'd1}};
        // R2: two sources raise SGI 5 on CPU 2
        gen_valid = 1; gen_src = 1; gen_sgi = 5; gen_targets = 4'b0100; step("R2");
        gen_src = 3; gen_targets = 4'b0110; step("R2");
        // R3: empty target mask and an out-of-range source change nothing
        gen_targets = 4'b0000; gen_src = 0; step("R3");
        gen_targets = 4'b1111; gen_src = 6; step("R3");
        idle(); step("R3");
        // R6: the acknowledges report source 1, then source 3
        ack_req = 4'b0100; step("R6");
        chk("R6 after first ack", 32'(rd_data[2*32+8 +: 8]), 32'h08);
        step("R6");
        idle(); step("R7");
        // R9: a generate and an acknowledge of the same bit collide
        gen_valid = 1; gen_src = 0; gen_sgi = 7; gen_targets = 4'b0001; step("R9");
        ack_req = 4'b0001; step("R9");
        idle();
        chk("R9 bit kept", 32'(rd_data[24 +: 8]), 32'h01);
        // R8: CPU 1 writes a clear that must not touch CPU 0
        clr_valid = 4'b0010; clr_id = {4'd0, 4'd0, 4'd7, 4'd0}; clr_mask = 32'h0000_FF00; step("R8");
        idle();
        chk("R8 other cpu kept", 32'(rd_data[24 +: 8]), 32'h01);
        // R8: CPU 0 clears its own source 0 of SGI 7, racing a generate (R9)
        clr_valid = 4'b0001; clr_id = {4'd0, 4'd0, 4'd0, 4'd7}; clr_mask = 32'h01;
        step("R8");
        idle();
        chk("R8 cleared", 32'(rd_data[24 +: 8]), 32'h00);
        clr_valid = 4'b0001; gen_valid = 1; gen_src = 0; gen_sgi = 7; gen_targets = 4'b0001;
        step("R9");
        idle(); step("R10"); step("R10");
        // Random mix with a fixed seed
        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            gen_valid   = ($urandom % 2) == 0;
            gen_src     = 3'($urandom);
            gen_sgi     = 4'($urandom);
            gen_targets = NC'($urandom);
            for (int c = 0; c < NC; c++) begin
                ack_req[c]   = ($urandom % 4) == 0;
                clr_valid[c] = ($urandom % 10) == 0;
            end
            clr_id   = NC*4'($urandom);
            clr_mask = NC*8'($urandom);
            rd_idx   = NC*2'($urandom);
            step("R2 R6 R8 R9 R10");
        end
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule